// File: doc/BRIEF.md
# Power-Fail Gated Chip-Enable Decoder

This block selects one of four battery-backed RAMs from a shared active-low chip-enable request and a 2-bit bank address. While the supply is in tolerance it works as a plain 1-of-4 active-low decoder. The address path to the outputs is combinational, so an address change during an access shows up at the outputs without waiting for a clock.

The block protects the RAMs around power events. A supply-good flag comes from an external comparator and passes through a two-flop synchronizer. When the flag drops, the block forces every output high. It waits only for the end of an access that is already under way, and during that access the outputs stay frozen. When the flag returns, the block samples two battery-good flags and waits a fixed number of clock cycles before decoding again. If both batteries were reported low at that restore, the second memory access after recovery is suppressed. Software can find this with a read, write, read test.

Top module: `pf_bank_select`

The controller is a four-state machine:
- PROTECT: all outputs high.
- RECOVER: recovery timer running, outputs high.
- ACTIVE: outputs decoded.
- HOLD: outputs frozen until the access ends.

It has these transitions:
- PROTECT to RECOVER when the synchronized supply is good. The batteries are sampled on this transition.
- RECOVER to PROTECT if the supply drops again.
- RECOVER to ACTIVE when the timer expires.
- ACTIVE to PROTECT on supply loss with the request high.
- ACTIVE to HOLD on supply loss with the request low.
- HOLD to PROTECT when the request rises.

## Requirements
- R1: In ACTIVE with the request low, address 0, 1, 2, 3 (bit 1 is the high-order bit) drives low only output bit 0, 1, 2, 3 of `ce_out_n` respectively. At most one output is ever low.
- R2: Whenever `ce_in_n` is high, all four outputs are high, whatever the address.
- R3: After supply loss with no access in progress, all outputs stay high, even if a request is made.
- R4: If supply loss is seen while the request is low, the outputs keep their last decoded value and ignore address changes until `ce_in_n` rises. From then on they are high.
- R5: A supply-good rise is seen on the third clock edge. Outputs stay high for RECOVER_CYCLES further edges and then decode. A supply drop during recovery restarts the whole interval.
- R6: While the request is low in ACTIVE, an address change reaches the outputs with no clock edge.
- R7: If both battery flags are low when the supply returns, the second access after recovery is held all-high. The first and third accesses decode normally. An access ends on a rising edge of `ce_in_n` sampled by the clock. Battery flags are ignored at other times.
- R8: If at least one battery flag is high at restore, no access is suppressed.
- R9: An active-low reset forces all outputs high at once. It also requires a full synchronizer and recovery delay afterwards, even if the supply is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in_n | input | 1 | Active-low access request |
| bank_addr | input | 2 | Bank select, bit 1 high-order |
| supply_ok | input | 1 | Asynchronous supply-in-tolerance flag |
| batt1_ok | input | 1 | Battery 1 above threshold |
| batt2_ok | input | 1 | Battery 2 above threshold |
| ce_out_n | output | 4 | Active-low chip enables to the four RAMs |

## Verification
A wrong state in this controller shows at the outputs within one clock edge of the event that should have moved it. A machine stuck in RECOVER keeps all enables high past the expected edge. A missed move into HOLD lets an address change during power loss reach the RAMs at once. A missing move out of HOLD leaves a stale enable low after the request rises. A wrong access count or battery sample shows only on the second access after a restore. For that reason the bench performs three accesses after each restore, counted from known edges.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int NBANK = 4;
    localparam int ABITS = $clog2(NBANK);

    typedef enum logic [1:0] {
        ST_PROTECT = 2'd0,
        ST_RECOVER = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_HOLD    = 2'd3
    } pfd_state_e;

    localparam logic [1:0] CYC_SAT = 2'd2;
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pfd_recovery_timer.sv
module pfd_recovery_timer #(
    parameter int RECOVER_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(RECOVER_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(RECOVER_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= '0;
        else if (run && !done)  cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pfd_decoder.sv
module pfd_decoder
    import pfd_pkg::*;
(
    input  logic             en_n,
    input  logic [ABITS-1:0] addr,
    output logic [NBANK-1:0] dec_n
);
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        assign dec_n[k] = en_n | (addr != ABITS'(k));
    end
endmodule

// File: rtl/pf_bank_select.sv
module pf_bank_select
    import pfd_pkg::*;
#(
    parameter int RECOVER_CYCLES = 1_000_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_in_n,
    input  logic [1:0] bank_addr,
    input  logic       supply_ok,
    input  logic       batt1_ok,
    input  logic       batt2_ok,
    output logic [3:0] ce_out_n
);
    pfd_state_e       state_q, state_d;
    logic             sup_s;
    logic             rec_start, rec_done;
    logic             batt_low_q;
    logic             ce_prev_q;
    logic [1:0]       cyc_q;
    logic [NBANK-1:0] dec_n, held_q;
    logic             inhibit;

    pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(supply_ok), .q_sync(sup_s)
    );

    pfd_recovery_timer #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(rec_start),
        .run(state_q == ST_RECOVER), .done(rec_done)
    );

    pfd_decoder u_dec (
        .en_n(ce_in_n), .addr(bank_addr), .dec_n(dec_n)
    );

    assign rec_start = (state_q == ST_PROTECT) && sup_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PROTECT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PROTECT: if (sup_s) state_d = ST_RECOVER;
            ST_RECOVER: begin
                if (!sup_s)        state_d = ST_PROTECT;
                else if (rec_done) state_d = ST_ACTIVE;
            end
            ST_ACTIVE:  if (!sup_s) state_d = ce_in_n ? ST_PROTECT : ST_HOLD;
            ST_HOLD:    if (ce_in_n) state_d = ST_PROTECT;
        endcase
    end

    // battery sample, access counting, freeze register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            batt_low_q <= 1'b0;
            ce_prev_q  <= 1'b1;
            cyc_q      <= '0;
            held_q     <= '1;
        end else begin
            ce_prev_q <= ce_in_n;
            if (rec_start) batt_low_q <= !(batt1_ok || batt2_ok);
            if (state_q != ST_ACTIVE)
                cyc_q <= '0;
            else if (ce_in_n && !ce_prev_q && cyc_q != CYC_SAT)
                cyc_q <= cyc_q + 1'b1;
            if (state_q == ST_ACTIVE) held_q <= ce_out_n;
        end
    end

    assign inhibit = batt_low_q && (cyc_q == 2'd1);

    // outputs
    always_comb begin
        ce_out_n = '1;
        unique case (state_q)
            ST_PROTECT: ce_out_n = '1;
            ST_RECOVER: ce_out_n = '1;
            ST_ACTIVE:  ce_out_n = inhibit ? '1 : dec_n;
            ST_HOLD:    ce_out_n = ce_in_n ? '1 : held_q;
        endcase
    end
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker
    import pfd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_in_n,
    input logic [3:0] ce_out_n,
    input pfd_state_e state,
    input logic [1:0] cyc,
    input logic       batt_low,
    input logic       rec_done
);
    assert_one_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ce_out_n) <= 1);

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_in_n |-> (ce_out_n == 4'hF));

    assert_protect_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROTECT) |-> (ce_out_n == 4'hF));

    assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !ce_in_n) |=>
        ((state == ST_HOLD && !ce_in_n) ? (ce_out_n == $past(ce_out_n)) : 1'b1));

    assert_recover_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER) |-> (ce_out_n == 4'hF));

    assert_recover_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && !rec_done) |=> (state != ST_ACTIVE));

    assert_second_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && cyc == 2'd1 && batt_low) |-> (ce_out_n == 4'hF));
endmodule

bind pf_bank_select pfd_checker u_pfd_checker (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .ce_out_n(ce_out_n),
    .state(state_q), .cyc(cyc_q), .batt_low(batt_low_q), .rec_done(rec_done)
);

// File: tb/test_pf_bank_select.sv
`timescale 1ns/1ps
module test_pf_bank_select;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n, ce_in_n, supply_ok, batt1_ok, batt2_ok;
    logic [1:0] bank_addr;
    logic [3:0] ce_out_n;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pf_bank_select #(.RECOVER_CYCLES(N)) i_pf_bank_select (
        .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .bank_addr(bank_addr),
        .supply_ok(supply_ok), .batt1_ok(batt1_ok), .batt2_ok(batt2_ok),
        .ce_out_n(ce_out_n)
    );

    // {ce_in_n, bank_addr, expected ce_out_n}
    localparam logic [6:0] VEC [8] = '{
        7'b0_00_1110, 7'b0_01_1101, 7'b0_10_1011, 7'b0_11_0111,
        7'b1_11_1111, 7'b1_00_1111, 7'b0_10_1011, 7'b0_01_1101
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        #1;
        checks++;
        if (ce_out_n !== exp) begin
            errors++;
            $display("FAIL %s: ce_out_n=%b expected=%b", req, ce_out_n, exp);
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ce_in_n = 1'b1; bank_addr = 2'd0;
        supply_ok = 1'b0; batt1_ok = 1'b1; batt2_ok = 1'b1;
        cyc(3);
        check("R9 reset", 4'hF);
        ce_in_n = 1'b0;
        check("R9 reset with request", 4'hF);
        rst_n = 1'b1;

        // power up, request low on bank 0
        supply_ok = 1'b1;
        cyc(N + 2);
        check("R5 still recovering", 4'hF);
        cyc(1);
        check("R5 recovery over", 4'b1110);

        // table walk
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            {ce_in_n, bank_addr} = VEC[i][6:4];
            check("R1 R2 table", VEC[i][3:0]);
        end

        // address tracking with no clock edge
        cyc(1);
        ce_in_n = 1'b0; bank_addr = 2'd3;
        check("R6 track a", 4'b0111);
        bank_addr = 2'd0;
        check("R6 track b", 4'b1110);

        // supply loss with no access
        cyc(1);
        ce_in_n = 1'b1; supply_ok = 1'b0;
        cyc(3);
        check("R3 protected", 4'hF);
        ce_in_n = 1'b0; bank_addr = 2'd1;
        check("R3 request blocked", 4'hF);
        cyc(2);
        check("R3 still blocked", 4'hF);

        // restore with both batteries low
        ce_in_n = 1'b1; batt1_ok = 1'b0; batt2_ok = 1'b0; supply_ok = 1'b1;
        cyc(N + 3);
        batt1_ok = 1'b1; batt2_ok = 1'b1;
        ce_in_n = 1'b0; bank_addr = 2'd2;
        check("R7 first access", 4'b1011);
        cyc(1); ce_in_n = 1'b1; cyc(2); ce_in_n = 1'b0;
        check("R7 second access inhibited", 4'hF);
        cyc(1); ce_in_n = 1'b1; cyc(2); ce_in_n = 1'b0;
        check("R7 third access", 4'b1011);
        cyc(1); ce_in_n = 1'b1; cyc(1);

        // restore with one battery low
        supply_ok = 1'b0;
        cyc(3);
        batt1_ok = 1'b0; batt2_ok = 1'b1; supply_ok = 1'b1;
        cyc(N + 3);
        ce_in_n = 1'b0; bank_addr = 2'd1;
        check("R8 first access", 4'b1101);
        cyc(1); ce_in_n = 1'b1; cyc(2); ce_in_n = 1'b0;
        check("R8 second access", 4'b1101);
        cyc(1); ce_in_n = 1'b1; cyc(1);

        // supply loss during an access
        ce_in_n = 1'b0; bank_addr = 2'd3;
        check("R1 bank 3", 4'b0111);
        cyc(1);
        supply_ok = 1'b0;
        cyc(3);
        bank_addr = 2'd0;
        check("R4 held on address change", 4'b0111);
        cyc(2);
        check("R4 still held", 4'b0111);
        ce_in_n = 1'b1;
        check("R4 released high", 4'hF);
        cyc(1);
        ce_in_n = 1'b0;
        check("R4 protected after release", 4'hF);

        // supply glitch during recovery restarts the interval
        supply_ok = 1'b1;
        cyc(5);
        supply_ok = 1'b0;
        cyc(3);
        supply_ok = 1'b1;
        cyc(N + 2);
        check("R5 restarted interval", 4'hF);
        cyc(1);
        check("R5 active after restart", 4'b1110);

        // reset while active
        cyc(1);
        rst_n = 1'b0;
        check("R9 async reset", 4'hF);
        cyc(2);
        rst_n = 1'b1;
        cyc(N + 2);
        check("R9 recovery after reset", 4'hF);
        cyc(1);
        check("R9 active after reset", 4'b1110);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule